// File: doc/BRIEF.md
# Memory Region Permission Checker

This block stores the settings for a bank of memory protection regions and answers, in the same cycle, what a given access may do. Each region has an 8-bit setting byte and a 32-bit address register. A single register port writes these settings and reads them back. The settings bytes are packed four to a 32-bit word. A query port takes a byte address, the privilege level (machine or user) and the kind of access. It returns the allowed execute/write/read bits and a single allow flag for that access kind.

A region is either off, matches one naturally aligned power-of-two block, or matches a single 32-bit word. The lowest-numbered matching region alone decides the outcome. Machine mode ignores any region that is not locked. When no region matches, machine mode gets everything and user mode gets nothing.

The query path is purely combinational and has no handshake, so the surrounding pipeline sees a result in the same cycle it presents an address. A register write takes effect at the next rising clock edge. Read data on the register port is combinational from the select input.

Top module: `memprot_checker`

## Requirements
- R1: After reset, every settings word and every address register reads back as zero.
- R2: A settings word write keeps only the bits under mask 0x9F9F9F9F, so bits 6:5 of each byte read back as zero. An address register write stores all 32 bits.
- R3: Each region's setting byte uses this layout. Bits 2:0 are the permissions: bit 0 read, bit 1 write, bit 2 execute. Bits 4:3 are the match mode, and bit 7 is the lock. Region i lives in byte i%4 of settings word i/4. Mode 0 means off, and an off region never matches.
- R4: In mode 2, let t be the number of trailing ones in the address register. The compare mask is 0xFFFFFFFE shifted left by t, and the mask is zero when the register is all ones. The region matches when the word address (addr>>2) and the register are equal under that mask.
- R5: Modes 1 and 3 match only when the word address (addr>>2) equals the whole address register.
- R6: When several regions match, the one with the lowest index alone sets the result.
- R7: In machine mode, a matching unlocked region yields permission 0b111. A matching locked region yields its own permission bits.
- R8: When no region matches, machine mode yields 0b111 and user mode yields 0b000.
- R9: In user mode, a matching region yields its own permission bits whether it is locked or not.
- R10: The access kind is 0 for a load, which needs the read bit, 1 for a store, which needs the write bit, and 2 for a fetch, which needs the execute bit. Kind 3 is never allowed.
- R11: The register select has 5 bits. Values 16+i select address register i. Values 0 to 3 select settings words 0 to 3. Values 4 to 15 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr_en | input | 1 | Write strobe for the register port |
| csr_sel | input | 5 | Register select (see R11) |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for the selected register |
| q_addr | input | 32 | Byte address under test |
| q_machine | input | 1 | 1 = machine mode, 0 = user mode |
| q_kind | input | 2 | Access kind (see R10) |
| q_perm | output | 3 | Allowed execute/write/read bits |
| q_allow | output | 1 | Access of kind q_kind is permitted |

## Verification
A corrupted settings byte or address register shows up at the ports at once. It appears on csr_rdata when that register is selected, and on q_perm as soon as a query address falls near that region's boundary. Wrong mask arithmetic shows only at the exact edges of a power-of-two block, so the queries probe the first and last words inside the block and the words just outside it. A priority fault needs two overlapping regions with different permissions to become visible, and the tests build that overlap in both index orders.

// File: rtl/memprot_pkg.sv
package memprot_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_WORD  = 2'd1,
    MODE_NAPOT = 2'd2,
    MODE_WORD3 = 2'd3
  } match_mode_e;

  typedef struct packed {
    logic        lock;
    logic [1:0]  rsvd;
    match_mode_e mode;
    logic [2:0]  xwr;
  } region_cfg_t;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_NONE  = 2'd3
  } access_kind_e;

  localparam logic [7:0] CFG_BYTE_KEEP = 8'h9F;
  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;

endpackage

// File: rtl/memprot_regs.sv
module memprot_regs
  import memprot_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int XLEN        = 32
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [$clog2(NUM_REGIONS):0]         sel,
  input  logic [XLEN-1:0]                      wdata,
  output logic [XLEN-1:0]                      rdata,
  output region_cfg_t [NUM_REGIONS-1:0]        cfg_o,
  output logic [NUM_REGIONS-1:0][XLEN-1:0]     addr_o
);

  localparam int IDX_W     = $clog2(NUM_REGIONS);
  localparam int PER_WORD  = XLEN / 8;
  localparam int CFG_WORDS = NUM_REGIONS / PER_WORD;
  localparam int CW_W      = $clog2(CFG_WORDS);
  localparam logic [XLEN-1:0] KEEP_WORD = {PER_WORD{CFG_BYTE_KEEP}};

  logic [CFG_WORDS-1:0][XLEN-1:0]   cfg_q;
  logic [NUM_REGIONS-1:0][XLEN-1:0] addr_q;

  logic             is_addr;
  logic [IDX_W-1:0] idx;
  logic             cfg_idx_ok;

  assign is_addr    = sel[IDX_W];
  assign idx        = sel[IDX_W-1:0];
  assign cfg_idx_ok = (idx < IDX_W'(CFG_WORDS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      addr_q <= '0;
    end else if (wr_en) begin
      for (int w = 0; w < CFG_WORDS; w++) begin
        if (!is_addr && idx == IDX_W'(w)) cfg_q[w] <= wdata & KEEP_WORD;
      end
      for (int r = 0; r < NUM_REGIONS; r++) begin
        if (is_addr && idx == IDX_W'(r)) addr_q[r] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (is_addr)         rdata = addr_q[idx];
    else if (cfg_idx_ok) rdata = cfg_q[idx[CW_W-1:0]];
  end

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_unpack
    assign cfg_o[i] = region_cfg_t'(cfg_q[i / PER_WORD][8*(i % PER_WORD) +: 8]);
  end

  assign addr_o = addr_q;

  AST_ADDR_FULL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_addr) |=> (addr_q[$past(idx)] == $past(wdata))) else $error("AST_ADDR_FULL_STORE"); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(cfg_q) && $stable(addr_q))) else $error("AST_IDLE_HOLD"); // R11

  AST_BAD_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !is_addr && !cfg_idx_ok) |=> $stable(cfg_q)) else $error("AST_BAD_SEL_HOLD"); // R11

endmodule

// File: rtl/memprot_match.sv
module memprot_match
  import memprot_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int XLEN        = 32
) (
  input  logic [XLEN-1:0]                  q_addr,
  input  region_cfg_t [NUM_REGIONS-1:0]    cfg_i,
  input  logic [NUM_REGIONS-1:0][XLEN-1:0] addr_i,
  output logic [NUM_REGIONS-1:0]           hit_o
);

  logic [XLEN-1:0] word_addr;
  assign word_addr = {2'b00, q_addr[XLEN-1:2]};

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    logic [XLEN-1:0] low_ones;
    logic [XLEN-1:0] napot_mask;

    // a ^ (a+1) sets the trailing ones plus the next bit; an all-ones register gives a zero mask
    assign low_ones   = addr_i[i] ^ (addr_i[i] + XLEN'(1));
    assign napot_mask = ~low_ones;

    always_comb begin
      unique case (cfg_i[i].mode)
        MODE_OFF:   hit_o[i] = 1'b0;
        MODE_NAPOT: hit_o[i] = ((word_addr ^ addr_i[i]) & napot_mask) == '0;
        default:    hit_o[i] = (word_addr == addr_i[i]);
      endcase
    end
  end

endmodule

// File: rtl/memprot_resolve.sv
module memprot_resolve
  import memprot_pkg::*;
#(
  parameter int NUM_REGIONS = 16
) (
  input  logic [NUM_REGIONS-1:0]        hit_i,
  input  region_cfg_t [NUM_REGIONS-1:0] cfg_i,
  input  logic                          machine_i,
  output logic [2:0]                    perm_o
);

  logic       any_hit;
  logic [2:0] win_xwr;
  logic       win_lock;

  // scan downward so the lowest matching index is the last to write
  always_comb begin
    any_hit  = 1'b0;
    win_xwr  = 3'b000;
    win_lock = 1'b0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        any_hit  = 1'b1;
        win_xwr  = cfg_i[i].xwr;
        win_lock = cfg_i[i].lock;
      end
    end
  end

  always_comb begin
    if (any_hit)        perm_o = (machine_i && !win_lock) ? 3'b111 : win_xwr;
    else if (machine_i) perm_o = 3'b111;
    else                perm_o = 3'b000;
  end

endmodule

// File: rtl/memprot_checker.sv
module memprot_checker
  import memprot_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int XLEN        = 32,
  localparam int SEL_W      = $clog2(NUM_REGIONS) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_wr_en,
  input  logic [SEL_W-1:0] csr_sel,
  input  logic [XLEN-1:0]  csr_wdata,
  output logic [XLEN-1:0]  csr_rdata,
  input  logic [XLEN-1:0]  q_addr,
  input  logic             q_machine,
  input  logic [1:0]       q_kind,
  output logic [2:0]       q_perm,
  output logic             q_allow
);

  region_cfg_t [NUM_REGIONS-1:0]    cfg;
  logic [NUM_REGIONS-1:0][XLEN-1:0] addr_regs;
  logic [NUM_REGIONS-1:0]           hit_vec;
  access_kind_e                     kind;

  memprot_regs #(.NUM_REGIONS(NUM_REGIONS), .XLEN(XLEN)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (csr_wr_en),
    .sel    (csr_sel),
    .wdata  (csr_wdata),
    .rdata  (csr_rdata),
    .cfg_o  (cfg),
    .addr_o (addr_regs)
  );

  memprot_match #(.NUM_REGIONS(NUM_REGIONS), .XLEN(XLEN)) u_match (
    .q_addr (q_addr),
    .cfg_i  (cfg),
    .addr_i (addr_regs),
    .hit_o  (hit_vec)
  );

  memprot_resolve #(.NUM_REGIONS(NUM_REGIONS)) u_resolve (
    .hit_i     (hit_vec),
    .cfg_i     (cfg),
    .machine_i (q_machine),
    .perm_o    (q_perm)
  );

  assign kind = access_kind_e'(q_kind);

  always_comb begin
    unique case (kind)
      ACC_LOAD:  q_allow = q_perm[PERM_R];
      ACC_STORE: q_allow = q_perm[PERM_W];
      ACC_FETCH: q_allow = q_perm[PERM_X];
      default:   q_allow = 1'b0;
    endcase
  end

  AST_USER_MISS_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_machine && hit_vec == '0) |-> (q_perm == 3'b000)) else $error("AST_USER_MISS_DENY"); // R8

  AST_MACHINE_MISS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (q_machine && hit_vec == '0) |-> (q_perm == 3'b111)) else $error("AST_MACHINE_MISS_FULL"); // R8

  AST_REGION0_DECIDES: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec[0] && !q_machine) |-> (q_perm == cfg[0].xwr)) else $error("AST_REGION0_DECIDES"); // R6

  AST_MACHINE_UNLOCKED_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec[0] && q_machine && !cfg[0].lock) |-> (q_perm == 3'b111)) else $error("AST_MACHINE_UNLOCKED_FULL"); // R7

  AST_KIND_NONE_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (q_kind == 2'd3) |-> !q_allow) else $error("AST_KIND_NONE_DENY"); // R10

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_chk
    AST_OFF_NEVER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[i].mode == MODE_OFF) |-> !hit_vec[i]) else $error("AST_OFF_NEVER_HITS"); // R3
  end

endmodule

// File: tb/test_memprot_checker.sv
module test_memprot_checker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr_en = 1'b0;
  logic [4:0]  csr_sel = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic [31:0] q_addr = '0;
  logic        q_machine = 1'b0;
  logic [1:0]  q_kind = '0;
  logic [2:0]  q_perm;
  logic        q_allow;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  memprot_checker i_memprot_checker (
    .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .q_addr(q_addr),
    .q_machine(q_machine), .q_kind(q_kind), .q_perm(q_perm), .q_allow(q_allow)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] sel, logic [31:0] data);
    @(negedge clk);
    csr_sel = sel; csr_wdata = data; csr_wr_en = 1'b1;
    @(negedge clk);
    csr_wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] sel, output logic [31:0] data);
    @(negedge clk);
    csr_sel = sel;
    #1 data = csr_rdata;
  endtask

  function automatic logic [7:0] cb(bit lock, logic [1:0] mode, logic [2:0] xwr);
    return {lock, 2'b00, mode, xwr};
  endfunction

  task automatic set_region(int i, logic [7:0] b, logic [31:0] areg);
    logic [31:0] w;
    rd(5'(i / 4), w);
    w[8*(i % 4) +: 8] = b;
    wr(5'(i / 4), w);
    wr(5'(16 + i), areg);
  endtask

  task automatic clear_all();
    for (int k = 0; k < 4; k++) wr(5'(k), 32'h0);
    for (int k = 0; k < 16; k++) wr(5'(16 + k), 32'h0);
  endtask

  task automatic query(logic [31:0] a, bit m, logic [1:0] k, output logic [2:0] p, output logic al);
    @(negedge clk);
    q_addr = a; q_machine = m; q_kind = k;
    #1 p = q_perm; al = q_allow;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int s = 0; s < 32; s++) begin
      if (s < 4 || s >= 16) begin
        rd(5'(s), d);
        chk($sformatf("R1 reg %0d after reset", s), d, 32'h0);
      end
    end
  endtask

  task automatic t_write_mask();
    logic [31:0] d;
    wr(5'd1, 32'hFFFF_FFFF);
    rd(5'd1, d);
    chk("R2 settings mask", d, 32'h9F9F_9F9F);
    wr(5'd19, 32'hDEAD_BEEF);
    rd(5'd19, d);
    chk("R2 address full store", d, 32'hDEAD_BEEF);
    clear_all();
  endtask

  task automatic t_select();
    logic [31:0] d;
    wr(5'd2, 32'h0000_1F00);
    wr(5'd7, 32'h1111_1111);
    rd(5'd7, d);
    chk("R11 bad select reads zero", d, 32'h0);
    for (int k = 0; k < 4; k++) begin
      rd(5'(k), d);
      chk($sformatf("R11 word %0d untouched", k), d, (k == 2) ? 32'h0000_1F00 : 32'h0);
    end
    clear_all();
  endtask

  task automatic t_off();
    logic [2:0] p; logic al;
    set_region(0, cb(0, 2'd0, 3'b111), 32'h0000_0500);
    query(32'h0000_1400, 1'b0, 2'd0, p, al);
    chk("R3 off region ignored", 32'(p), 32'h0);
    clear_all();
  endtask

  task automatic t_napot();
    logic [2:0] p; logic al;
    set_region(0, cb(0, 2'd2, 3'b001), 32'h0000_0401);
    query(32'h0000_1000, 1'b0, 2'd0, p, al); chk("R4 napot first word", 32'(p), 32'h1);
    query(32'h0000_100F, 1'b0, 2'd0, p, al); chk("R4 napot last byte", 32'(p), 32'h1);
    query(32'h0000_1010, 1'b0, 2'd0, p, al); chk("R4 napot above", 32'(p), 32'h0);
    query(32'h0000_0FFC, 1'b0, 2'd0, p, al); chk("R4 napot below", 32'(p), 32'h0);
    set_region(0, cb(0, 2'd2, 3'b011), 32'hFFFF_FFFF);
    query(32'h0000_0000, 1'b0, 2'd0, p, al); chk("R4 all ones low", 32'(p), 32'h3);
    query(32'hFFFF_FFF0, 1'b0, 2'd0, p, al); chk("R4 all ones high", 32'(p), 32'h3);
    clear_all();
  endtask

  task automatic t_exact();
    logic [2:0] p; logic al;
    set_region(3, cb(0, 2'd1, 3'b100), 32'h0000_0800);
    query(32'h0000_2000, 1'b0, 2'd2, p, al); chk("R5 mode1 hit", 32'(p), 32'h4);
    query(32'h0000_2003, 1'b0, 2'd2, p, al); chk("R5 mode1 same word", 32'(p), 32'h4);
    query(32'h0000_2004, 1'b0, 2'd2, p, al); chk("R5 mode1 next word", 32'(p), 32'h0);
    set_region(3, cb(0, 2'd3, 3'b010), 32'h0000_0800);
    query(32'h0000_2000, 1'b0, 2'd1, p, al); chk("R5 mode3 hit", 32'(p), 32'h2);
    query(32'h0000_1FFC, 1'b0, 2'd1, p, al); chk("R5 mode3 miss", 32'(p), 32'h0);
    clear_all();
  endtask

  task automatic t_priority();
    logic [2:0] p; logic al;
    set_region(2, cb(0, 2'd2, 3'b001), 32'h0000_0C01);
    set_region(5, cb(0, 2'd1, 3'b110), 32'h0000_0C01);
    query(32'h0000_3004, 1'b0, 2'd0, p, al); chk("R6 lower napot wins", 32'(p), 32'h1);
    set_region(1, cb(0, 2'd1, 3'b110), 32'h0000_0C01);
    query(32'h0000_3004, 1'b0, 2'd0, p, al); chk("R6 lower exact wins", 32'(p), 32'h6);
    clear_all();
  endtask

  task automatic t_lock();
    logic [2:0] p; logic al;
    set_region(0, cb(0, 2'd1, 3'b001), 32'h0000_1000);
    query(32'h0000_4000, 1'b1, 2'd1, p, al); chk("R7 machine unlocked full", 32'(p), 32'h7);
    chk("R7 machine unlocked store allowed", 32'(al), 32'h1);
    query(32'h0000_4000, 1'b0, 2'd0, p, al); chk("R9 user unlocked perms", 32'(p), 32'h1);
    set_region(0, cb(1, 2'd1, 3'b001), 32'h0000_1000);
    query(32'h0000_4000, 1'b1, 2'd1, p, al); chk("R7 machine locked perms", 32'(p), 32'h1);
    chk("R7 machine locked store denied", 32'(al), 32'h0);
    query(32'h0000_4000, 1'b0, 2'd0, p, al); chk("R9 user locked perms", 32'(p), 32'h1);
    clear_all();
  endtask

  task automatic t_nomatch();
    logic [2:0] p; logic al;
    query(32'h1234_5678, 1'b1, 2'd2, p, al); chk("R8 machine miss", 32'(p), 32'h7);
    query(32'h1234_5678, 1'b0, 2'd2, p, al); chk("R8 user miss", 32'(p), 32'h0);
  endtask

  task automatic t_kinds();
    logic [2:0] p; logic al;
    set_region(0, cb(0, 2'd1, 3'b001), 32'h0000_1400);
    query(32'h0000_5000, 1'b0, 2'd0, p, al); chk("R10 load with read", 32'(al), 32'h1);
    query(32'h0000_5000, 1'b0, 2'd1, p, al); chk("R10 store no write", 32'(al), 32'h0);
    query(32'h0000_5000, 1'b0, 2'd2, p, al); chk("R10 fetch no exec", 32'(al), 32'h0);
    set_region(0, cb(0, 2'd1, 3'b100), 32'h0000_1400);
    query(32'h0000_5000, 1'b0, 2'd2, p, al); chk("R10 fetch with exec", 32'(al), 32'h1);
    query(32'h0000_9000, 1'b1, 2'd3, p, al); chk("R10 kind 3 denied", 32'(al), 32'h0);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_mask();
    t_select();
    t_off();
    t_napot();
    t_exact();
    t_priority();
    t_lock();
    t_nomatch();
    t_kinds();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule